// File: doc/BRIEF.md
# Compressed Instruction Expander

This block is a purely combinational decode stage that turns one 16-bit compressed RV32 integer instruction into the single 32-bit base instruction it stands for. A fetch or decode pipeline places the halfword on the input. In the same cycle it receives either a complete base-ISA word, which the rest of the decoder handles exactly like any other 32-bit instruction, or a raised illegal flag.

The low two bits pick one of three quadrants. Inside each quadrant, bits 15:13 pick the operation. Operand fields come in eight compact layouts:

- Register, immediate and stack-store layouts carry full 5-bit register numbers.
- Wide-immediate, load, store and branch layouts carry 3-bit numbers. A 3-bit number always means one of x8..x15.

Immediates arrive with their bits scrambled. The block reassembles them, sign-extends or zero-extends them, scales them where needed and places them in the base I, S, B, J or U field positions. Several encodings are reserved: an x0 operand where x0 is not allowed, a zero immediate where zero is not allowed, floating-point slots and 64-bit-only slots. These assert the illegal flag instead of producing a word.

Top module: `cx_expander`

## Requirements
- R1: An input whose bits 1:0 are 11 is reported illegal. Whenever the illegal output is high, the word output is all zeros.
- R2: The all-zero halfword is illegal. The stack-pointer add with the wide 8-bit immediate (quadrant 00, funct3 000) expands to `addi rd, x2, imm`, where imm is zero-extended and scaled by 4. This encoding is illegal when its immediate is zero.
- R3: A 3-bit register field with value n names register x(8+n). In the word output, rd sits in bits 11:7, rs1 in bits 19:15 and rs2 in bits 24:20.
- R4: A 5-bit destination field at input bits 11:7 is copied unchanged to output bits 11:7. This covers add-immediate, load-immediate, upper-immediate, left shift, stack load, move and add. The operation `addi x0,x0,0` comes from halfword 0x0001.
- R5: Every sign-extended immediate takes its sign from input bit 12. This covers add-immediate, load-immediate, and-immediate, stack-pointer adjust, upper-immediate, branches and jumps.
- R6: Word loads and stores expand to `lw`/`sw` with zero-extended offsets that are multiples of 4. The register-based pair reaches 0..124 and uses a 3-bit base. The stack-based pair reaches 0..252 and uses x2 as base.
- R7: Quadrant 01 funct3 110 expands to `beq rs1', x0, off` and funct3 111 expands to `bne rs1', x0, off`. The offset is a 9-bit signed even value placed in the B field.
- R8: Quadrant 01 funct3 101 expands to `jal x0, off` and funct3 001 expands to `jal x1, off`. The offset is a 12-bit signed even value placed in the J field.
- R9: Reserved x0 and zero-immediate forms are illegal. These are: stack load with rd=0, register jump with rs1=0, stack-pointer adjust with a zero immediate, and upper-immediate with a zero immediate.
- R10: Immediate shifts expand to `slli`, `srli` or `srai`, using a 5-bit shift amount. For `srai`, bits 31:25 are 0100000. If input bit 12 is set (shift amount 32 or more), the encoding is illegal.
- R11: Register operations expand to their R-type equivalents: `sub`/`xor`/`or`/`and` on x8..x15, move (`add rd,x0,rs2`) and add (`add rd,rd,rs2`). Register jump expands to `jalr x0,0(rs1)` and jump-and-link-register to `jalr x1,0(rs1)`. Halfword 0x9002 expands to 0x00100073.
- R12: Encodings with no RV32 integer meaning are illegal. These are: quadrant 00 funct3 001/011/100/101/111, quadrant 10 funct3 001/011/101/111, and quadrant 01 funct3 100 register-register forms with bit 12 set.
- R13: Every legal expansion has output bits 1:0 equal to 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cw_i | input | 16 | Compressed instruction halfword |
| word_o | output | 32 | Expanded RV32I instruction, zero when illegal |
| illegal_o | output | 1 | High when the halfword has no legal expansion |

## Verification
The checker evaluates on every input change the following: the quadrant-11 and all-zero rejections, the zeroed word on illegal input, the 11 length code on legal words, and stack loads with rd=0 being rejected. For add-immediate, load-immediate and register-based loads, it also checks the pass-through of rd, the sign taken from bit 12, and the x8..x15 mapping. The exact placement of every scrambled immediate bit cannot be checked this way, because the check would have to rebuild the same decode. Correct funct3/funct7 selection for each operation and the boundary offsets (largest scaled offsets, most negative branch and jump) are shown only by the bench. The bench encodes chosen operands into halfwords and compares the result against base words that it builds itself.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int CW_W  = 16;
  localparam int IW_W  = 32;
  localparam int REG_W = 5;
  localparam int RP_W  = 3;
  localparam int F3_W  = 3;
  localparam int OP_W  = 7;

  typedef logic [CW_W-1:0]  cword_t;
  typedef logic [IW_W-1:0]  iword_t;
  typedef logic [REG_W-1:0] reg_t;

  localparam logic [OP_W-1:0] OP_LOAD  = 7'b0000011;
  localparam logic [OP_W-1:0] OP_IMM   = 7'b0010011;
  localparam logic [OP_W-1:0] OP_STORE = 7'b0100011;
  localparam logic [OP_W-1:0] OP_REG   = 7'b0110011;
  localparam logic [OP_W-1:0] OP_LUI   = 7'b0110111;
  localparam logic [OP_W-1:0] OP_BR    = 7'b1100011;
  localparam logic [OP_W-1:0] OP_JALR  = 7'b1100111;
  localparam logic [OP_W-1:0] OP_JAL   = 7'b1101111;
  localparam iword_t          W_EBRK   = 32'h00100073;

  // 3-bit compact register number -> x8..x15
  function automatic reg_t prime(input logic [RP_W-1:0] n);
    return {2'b01, n};
  endfunction

  function automatic iword_t enc_i(input logic [11:0] imm, input reg_t rs1,
                                   input logic [F3_W-1:0] f3, input reg_t rd,
                                   input logic [OP_W-1:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic iword_t enc_s(input logic [11:0] imm, input reg_t rs2,
                                   input reg_t rs1, input logic [F3_W-1:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OP_STORE};
  endfunction

  function automatic iword_t enc_r(input logic [6:0] f7, input reg_t rs2,
                                   input reg_t rs1, input logic [F3_W-1:0] f3,
                                   input reg_t rd);
    return {f7, rs2, rs1, f3, rd, OP_REG};
  endfunction

  function automatic iword_t enc_b(input logic [12:0] imm, input reg_t rs1,
                                   input logic [F3_W-1:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], OP_BR};
  endfunction

  function automatic iword_t enc_j(input logic [20:0] imm, input reg_t rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OP_JAL};
  endfunction
endpackage

// File: rtl/cx_quad0.sv
module cx_quad0
  import cx_pkg::*;
(
  input  cword_t cw,
  output iword_t word,
  output logic   bad
);
  logic [9:0] wide_imm;
  logic [6:0] mem_off;
  reg_t       rd_p;
  reg_t       rs1_p;

  always_comb begin
    wide_imm = {cw[10:7], cw[12:11], cw[5], cw[6], 2'b00};
    mem_off  = {cw[5], cw[12:10], cw[6], 2'b00};
    rd_p     = prime(cw[4:2]);
    rs1_p    = prime(cw[9:7]);
    word     = '0;
    bad      = 1'b0;
    unique case (cw[15:13])
      3'b000: begin
        bad  = (wide_imm == '0);
        word = enc_i({2'b00, wide_imm}, 5'd2, 3'b000, rd_p, OP_IMM);
      end
      3'b010: word = enc_i({5'd0, mem_off}, rs1_p, 3'b010, rd_p, OP_LOAD);
      3'b110: word = enc_s({5'd0, mem_off}, rd_p, rs1_p, 3'b010);
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/cx_quad1.sv
module cx_quad1
  import cx_pkg::*;
(
  input  cword_t cw,
  output iword_t word,
  output logic   bad
);
  logic [11:0] imm6_sx;
  logic [11:0] sp_adj;
  logic [20:0] jmp_off;
  logic [12:0] br_off;
  reg_t        rd;
  reg_t        rd_p;
  reg_t        rs2_p;

  always_comb begin
    rd      = cw[11:7];
    rd_p    = prime(cw[9:7]);
    rs2_p   = prime(cw[4:2]);
    imm6_sx = {{6{cw[12]}}, cw[12], cw[6:2]};
    sp_adj  = {{2{cw[12]}}, cw[12], cw[4:3], cw[5], cw[2], cw[6], 4'b0000};
    jmp_off = {{9{cw[12]}}, cw[12], cw[8], cw[10:9], cw[6], cw[7], cw[2],
               cw[11], cw[5:3], 1'b0};
    br_off  = {{4{cw[12]}}, cw[12], cw[6:5], cw[2], cw[11:10], cw[4:3], 1'b0};
    word    = '0;
    bad     = 1'b0;
    unique case (cw[15:13])
      3'b000: word = enc_i(imm6_sx, rd, 3'b000, rd, OP_IMM);
      3'b001: word = enc_j(jmp_off, 5'd1);
      3'b010: word = enc_i(imm6_sx, 5'd0, 3'b000, rd, OP_IMM);
      3'b011: begin
        if (rd == 5'd2) begin
          bad  = (sp_adj == '0);
          word = enc_i(sp_adj, 5'd2, 3'b000, 5'd2, OP_IMM);
        end else begin
          bad  = ({cw[12], cw[6:2]} == '0);
          word = {{14{cw[12]}}, cw[12], cw[6:2], rd, OP_LUI};
        end
      end
      3'b100: begin
        unique case (cw[11:10])
          2'b00: begin
            bad  = cw[12];
            word = enc_i({7'b0000000, cw[6:2]}, rd_p, 3'b101, rd_p, OP_IMM);
          end
          2'b01: begin
            bad  = cw[12];
            word = enc_i({7'b0100000, cw[6:2]}, rd_p, 3'b101, rd_p, OP_IMM);
          end
          2'b10: word = enc_i(imm6_sx, rd_p, 3'b111, rd_p, OP_IMM);
          default: begin
            bad = cw[12];
            unique case (cw[6:5])
              2'b00:   word = enc_r(7'b0100000, rs2_p, rd_p, 3'b000, rd_p);
              2'b01:   word = enc_r(7'b0000000, rs2_p, rd_p, 3'b100, rd_p);
              2'b10:   word = enc_r(7'b0000000, rs2_p, rd_p, 3'b110, rd_p);
              default: word = enc_r(7'b0000000, rs2_p, rd_p, 3'b111, rd_p);
            endcase
          end
        endcase
      end
      3'b101: word = enc_j(jmp_off, 5'd0);
      3'b110: word = enc_b(br_off, rd_p, 3'b000);
      default: word = enc_b(br_off, rd_p, 3'b001);
    endcase
  end
endmodule

// File: rtl/cx_quad2.sv
module cx_quad2
  import cx_pkg::*;
(
  input  cword_t cw,
  output iword_t word,
  output logic   bad
);
  reg_t       rd;
  reg_t       rs2;
  logic [7:0] ld_off;
  logic [7:0] st_off;

  always_comb begin
    rd     = cw[11:7];
    rs2    = cw[6:2];
    ld_off = {cw[3:2], cw[12], cw[6:4], 2'b00};
    st_off = {cw[8:7], cw[12:9], 2'b00};
    word   = '0;
    bad    = 1'b0;
    unique case (cw[15:13])
      3'b000: begin
        bad  = cw[12];
        word = enc_i({7'b0000000, cw[6:2]}, rd, 3'b001, rd, OP_IMM);
      end
      3'b010: begin
        bad  = (rd == '0);
        word = enc_i({4'd0, ld_off}, 5'd2, 3'b010, rd, OP_LOAD);
      end
      3'b100: begin
        if (!cw[12]) begin
          if (rs2 == '0) begin
            bad  = (rd == '0);
            word = enc_i(12'd0, rd, 3'b000, 5'd0, OP_JALR);
          end else begin
            word = enc_r(7'b0000000, rs2, 5'd0, 3'b000, rd);
          end
        end else if (rs2 == '0) begin
          word = (rd == '0) ? W_EBRK : enc_i(12'd0, rd, 3'b000, 5'd1, OP_JALR);
        end else begin
          word = enc_r(7'b0000000, rs2, rd, 3'b000, rd);
        end
      end
      3'b110: word = enc_s({4'd0, st_off}, rs2, 5'd2, 3'b010);
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
(
  input  logic [15:0] cw_i,
  output logic [31:0] word_o,
  output logic        illegal_o
);
  localparam int NQ = 3;

  iword_t   q_word [NQ];
  logic     q_bad  [NQ];

  cx_quad0 u_q0 (.cw(cw_i), .word(q_word[0]), .bad(q_bad[0]));
  cx_quad1 u_q1 (.cw(cw_i), .word(q_word[1]), .bad(q_bad[1]));
  cx_quad2 u_q2 (.cw(cw_i), .word(q_word[2]), .bad(q_bad[2]));

  iword_t sel_word;
  logic   sel_bad;

  always_comb begin
    unique case (cw_i[1:0])
      2'b00:   begin sel_word = q_word[0]; sel_bad = q_bad[0]; end
      2'b01:   begin sel_word = q_word[1]; sel_bad = q_bad[1]; end
      2'b10:   begin sel_word = q_word[2]; sel_bad = q_bad[2]; end
      default: begin sel_word = '0;        sel_bad = 1'b1;     end
    endcase
    illegal_o = sel_bad;
    word_o    = sel_bad ? '0 : sel_word;
  end
endmodule

// File: rtl/cx_expander_chk.sv
module cx_expander_chk (
  input logic [15:0] cw_i,
  input logic [31:0] word_o,
  input logic        illegal_o
);
  always_comb begin
    p_quad3_r1: assert (cw_i[1:0] != 2'b11 || illegal_o)
      else $error("quadrant 11 accepted");
    p_zero_out_r1: assert (!illegal_o || word_o == 32'd0)
      else $error("illegal with nonzero word");
    p_allzero_r2: assert (cw_i != 16'd0 || illegal_o)
      else $error("zero halfword accepted");
    p_len_code_r13: assert (illegal_o || word_o[1:0] == 2'b11)
      else $error("legal word lacks 11 code");
    p_rd_copy_r4: assert (!(cw_i[1:0] == 2'b01 && cw_i[15:13] == 3'b000 && !illegal_o)
                          || (word_o[11:7] == cw_i[11:7] && word_o[19:15] == cw_i[11:7]))
      else $error("rd not passed through");
    p_sign_r5: assert (!(cw_i[1:0] == 2'b01 && cw_i[15:13] == 3'b010 && !illegal_o)
                       || word_o[31] == cw_i[12])
      else $error("sign not from bit 12");
    p_prime_r3: assert (!(cw_i[1:0] == 2'b00 && cw_i[15:13] == 3'b010 && !illegal_o)
                        || (word_o[19:15] == {2'b01, cw_i[9:7]}
                            && word_o[11:7] == {2'b01, cw_i[4:2]}))
      else $error("compact register mapping wrong");
    p_lwsp_rd0_r9: assert (!(cw_i[1:0] == 2'b10 && cw_i[15:13] == 3'b010
                             && cw_i[11:7] == 5'd0) || illegal_o)
      else $error("stack load to x0 accepted");
  end
endmodule

bind cx_expander cx_expander_chk u_chk (.cw_i(cw_i), .word_o(word_o), .illegal_o(illegal_o));

// File: tb/sim_cx_expander.sv
module sim_cx_expander;
  logic        clk;
  logic        rst_n;
  logic [15:0] cw;
  logic [31:0] word;
  logic        ill;

  cx_expander u0 (.cw_i(cw), .word_o(word), .illegal_o(ill));

  typedef struct {
    logic [15:0] cw;
    logic [31:0] w;
    logic        bad;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  int    wd    = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // base-ISA builders
  function automatic logic [31:0] b_i(logic [11:0] im, logic [4:0] rs1, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] b_s(logic [11:0] im, logic [4:0] rs2, logic [4:0] rs1);
    return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] b_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h33};
  endfunction
  function automatic logic [31:0] b_b(logic [12:0] im, logic [4:0] rs1, logic [2:0] f3);
    return {im[12], im[10:5], 5'd0, rs1, f3, im[4:1], im[11], 7'h63};
  endfunction
  function automatic logic [31:0] b_j(logic [20:0] im, logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'h6F};
  endfunction

  // compressed builders
  function automatic logic [15:0] c_a4(logic [2:0] rd, logic [9:0] im);
    return {3'b000, im[5:4], im[9:6], im[2], im[3], rd, 2'b00};
  endfunction
  function automatic logic [15:0] c_mem(logic [2:0] f3, logic [2:0] r2, logic [2:0] r1, logic [6:0] o);
    return {f3, o[5:3], r1, o[2], o[6], r2, 2'b00};
  endfunction
  function automatic logic [15:0] c_ci(logic [2:0] f3, logic [4:0] rd, logic [5:0] im, logic [1:0] qd);
    return {f3, im[5], rd, im[4:0], qd};
  endfunction
  function automatic logic [15:0] c_lwsp(logic [4:0] rd, logic [7:0] o);
    return {3'b010, o[5], rd, o[4:2], o[7:6], 2'b10};
  endfunction
  function automatic logic [15:0] c_swsp(logic [4:0] rs, logic [7:0] o);
    return {3'b110, o[5:2], o[7:6], rs, 2'b10};
  endfunction
  function automatic logic [15:0] c_cj(logic [2:0] f3, logic [11:0] o);
    return {f3, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_cb(logic [2:0] f3, logic [2:0] rs, logic [8:0] o);
    return {f3, o[8], o[4:3], rs, o[7:6], o[2:1], o[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_sp(logic [9:0] i);
    return {3'b011, i[9], 5'd2, i[4], i[6], i[8:7], i[5], 2'b01};
  endfunction
  function automatic logic [15:0] c_alu(logic b12, logic [1:0] f2, logic [2:0] rd, logic [4:0] lo);
    return {3'b100, b12, f2, rd, lo, 2'b01};
  endfunction
  function automatic logic [15:0] c_cr(logic [3:0] f4, logic [4:0] rd, logic [4:0] rs2);
    return {f4, rd, rs2, 2'b10};
  endfunction

  task automatic drive(logic [15:0] c, logic [31:0] w, logic b, string tag);
    item_t it;
    @(negedge clk);
    cw = c;
    it.cw = c; it.w = b ? 32'd0 : w; it.bad = b; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (word !== it.w || ill !== it.bad) begin
        n_bad++;
        $display("FAIL %s cw=%h actual word=%h ill=%b expected word=%h ill=%b",
                 it.tag, it.cw, word, ill, it.w, it.bad);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cw    = 16'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(16'h0000, 0, 1, "R2 zero halfword");
    drive(16'h0003, 0, 1, "R1 quadrant 11");
    drive(16'hFFFF, 0, 1, "R1 quadrant 11 all ones");
    drive(c_a4(3'd5, 10'h3FC), b_i(12'd1020, 5'd2, 3'd0, 5'd13, 7'h13), 0, "R2 R3 addi4spn max");
    drive(c_a4(3'd0, 10'd4), b_i(12'd4, 5'd2, 3'd0, 5'd8, 7'h13), 0, "R2 addi4spn min");
    drive(c_a4(3'd3, 10'd0), 0, 1, "R2 addi4spn zero imm");
    drive(c_mem(3'b010, 3'd1, 3'd7, 7'd124), b_i(12'd124, 5'd15, 3'd2, 5'd9, 7'h03), 0, "R6 R3 lw max");
    drive(c_mem(3'b110, 3'd2, 3'd0, 7'd64), b_s(12'd64, 5'd10, 5'd8), 0, "R6 R3 sw");
    drive(16'h0001, 32'h00000013, 0, "R4 nop");
    drive(c_ci(3'b000, 5'd5, 6'h3F, 2'b01), b_i(12'hFFF, 5'd5, 3'd0, 5'd5, 7'h13), 0, "R4 R5 addi -1");
    drive(c_ci(3'b010, 5'd31, 6'h1F, 2'b01), b_i(12'd31, 5'd0, 3'd0, 5'd31, 7'h13), 0, "R4 R5 li +31");
    drive(c_ci(3'b011, 5'd7, 6'h20, 2'b01), {20'hFFFE0, 5'd7, 7'h37}, 0, "R5 R4 lui negative");
    drive(c_ci(3'b011, 5'd7, 6'h00, 2'b01), 0, 1, "R9 lui zero imm");
    drive(c_sp(10'h3F0), b_i(12'hFF0, 5'd2, 3'd0, 5'd2, 7'h13), 0, "R5 addi16sp -16");
    drive(c_sp(10'd0), 0, 1, "R9 addi16sp zero");
    drive(c_alu(1'b0, 2'b00, 3'd4, 5'd31), b_i(12'd31, 5'd12, 3'd5, 5'd12, 7'h13), 0, "R10 srli");
    drive(c_alu(1'b0, 2'b01, 3'd0, 5'd1), b_i({7'h20, 5'd1}, 5'd8, 3'd5, 5'd8, 7'h13), 0, "R10 srai");
    drive(c_alu(1'b1, 2'b00, 3'd4, 5'd1), 0, 1, "R10 srli shamt 33");
    drive(c_alu(1'b1, 2'b10, 3'd3, 5'h18), b_i(12'hFF8, 5'd11, 3'd7, 5'd11, 7'h13), 0, "R5 andi -8");
    drive(c_alu(1'b0, 2'b11, 3'd2, {2'b00, 3'd5}), b_r(7'h20, 5'd13, 5'd10, 3'd0, 5'd10), 0, "R11 sub");
    drive(c_alu(1'b0, 2'b11, 3'd2, {2'b01, 3'd5}), b_r(7'h00, 5'd13, 5'd10, 3'd4, 5'd10), 0, "R11 xor");
    drive(c_alu(1'b0, 2'b11, 3'd2, {2'b10, 3'd5}), b_r(7'h00, 5'd13, 5'd10, 3'd6, 5'd10), 0, "R11 or");
    drive(c_alu(1'b0, 2'b11, 3'd2, {2'b11, 3'd5}), b_r(7'h00, 5'd13, 5'd10, 3'd7, 5'd10), 0, "R11 and");
    drive(c_alu(1'b1, 2'b11, 3'd2, {2'b00, 3'd5}), 0, 1, "R12 reg op bit12");
    drive(c_cj(3'b101, 12'h800), b_j(21'h1FF800, 5'd0), 0, "R8 j most negative");
    drive(c_cj(3'b001, 12'h7FE), b_j(21'h0007FE, 5'd1), 0, "R8 jal max");
    drive(c_cb(3'b110, 3'd6, 9'h100), b_b(13'h1F00, 5'd14, 3'd0), 0, "R7 beqz most negative");
    drive(c_cb(3'b111, 3'd1, 9'h0FE), b_b(13'h00FE, 5'd9, 3'd1), 0, "R7 bnez max");
    drive(c_ci(3'b000, 5'd9, 6'd12, 2'b10), b_i(12'd12, 5'd9, 3'd1, 5'd9, 7'h13), 0, "R10 R4 slli");
    drive(c_ci(3'b000, 5'd9, 6'h21, 2'b10), 0, 1, "R10 slli shamt 33");
    drive(c_lwsp(5'd20, 8'd252), b_i(12'd252, 5'd2, 3'd2, 5'd20, 7'h03), 0, "R6 R4 lwsp max");
    drive(c_lwsp(5'd0, 8'd8), 0, 1, "R9 lwsp rd0");
    drive(c_swsp(5'd31, 8'd188), b_s(12'd188, 5'd31, 5'd2), 0, "R6 swsp");
    drive(c_cr(4'b1000, 5'd1, 5'd0), 32'h00008067, 0, "R11 jr ra");
    drive(c_cr(4'b1000, 5'd0, 5'd0), 0, 1, "R9 jr x0");
    drive(c_cr(4'b1000, 5'd10, 5'd11), b_r(7'h00, 5'd11, 5'd0, 3'd0, 5'd10), 0, "R11 R4 mv");
    drive(c_cr(4'b1001, 5'd10, 5'd11), b_r(7'h00, 5'd11, 5'd10, 3'd0, 5'd10), 0, "R11 R4 add");
    drive(c_cr(4'b1001, 5'd5, 5'd0), b_i(12'd0, 5'd5, 3'd0, 5'd1, 7'h67), 0, "R11 jalr");
    drive(16'h9002, 32'h00100073, 0, "R11 ebreak");
    drive(16'h2004, 0, 1, "R12 q0 funct3 001");
    drive(16'h8004, 0, 1, "R12 q0 funct3 100");
    drive(16'h6082, 0, 1, "R12 q2 funct3 011");
    drive(16'hE082, 0, 1, "R12 q2 funct3 111");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule